// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a NOR-style flash store. A host issues single-cycle writes and reads on one shared address bus, and the block decodes fixed multi-write sequences into embedded operations: word program, sector erase, suspend and resume. The operations run on a small on-chip array split into equal sectors. Each embedded operation takes a fixed number of cycles, and its duration is a parameter.

While an operation runs, the host polls with ordinary reads, which then return a status word in place of array data. It can also watch the `ready` output. A shortcut mode cuts a program down to two writes. Suspending an erase lets the host read and program other sectors. Suspending a program only allows reads of other sectors. The reset input aborts whatever is in progress and returns the block to plain read mode.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: The writes AA at 0x555, then 55 at 0x2AA, then A0 at 0x555, followed by a write of address and data, start a word program. Command bytes are in bits 7:0, and the unlock addresses are compared on address bits 11:0. When the program ends, the word holds the new value.
- R2: A program only clears bits. The stored word becomes the old word ANDed with the written data.
- R3: AA at 0x555, 55 at 0x2AA, then 20 at 0x555 enters shortcut mode. In that mode, A0 at any address followed by an address and data write starts a program. 90 followed by 00, both at any address, leaves the mode. After that, a two-write program changes nothing.
- R4: AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, then 30 written to an address inside a sector, erases that sector. Erase sets every word in the sector to 0xFFFF and leaves the other sectors unchanged. Sector = address bits 5:4 and word = bits 3:0 in the default configuration.
- R5: A write that does not match the expected step of a sequence drops the sequence. No operation starts, `ready` stays high, and the array is unchanged.
- R6: `ready` falls in the cycle after the last write of an accepted command. It stays low for PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, not counting cycles spent suspended.
- R7: A read while an operation runs returns a status word one cycle later. In that word, bit 7 is the complement of bit 7 of the data being written (0 during erase). Bit 6 is 0 on the first status read after reset and inverts on each further status read. All other bits are 0.
- R8: Writing B0 during a running erase suspends it, and `ready` is high in the next cycle. During the suspend:
  - reads of other sectors return data;
  - reads of the suspended sector return status;
  - programs to other sectors run;
  - a program to the suspended sector is ignored;
  - a new erase is refused.
  A single write of 30 resumes the erase, and the erase then finishes.
- R9: Writing B0 during a running program suspends it. During this suspend, reads of other sectors return data and reads of its sector return status. Every write other than 30 is ignored. A write of 30 resumes the program, and the program then completes.
- R10: Asserting `rst_n` low aborts any operation, leaves shortcut mode and any suspend, and fills the array with 0xFFFF. After release, `ready` is high and new commands work.
- R11: While `ready` is low, every write except B0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset and abort |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, data returned next cycle |
| host_addr | input | ADDR_W | Shared read and write address |
| host_wdata | input | 16 | Write data; command byte in bits 7:0 |
| host_rdata | output | 16 | Registered read data or status word |
| ready | output | 1 | High when no operation is running |

## Verification
Programs are tried with several kinds of data:
- data with bit 7 set and with bit 7 clear, so that the polled bit 7 shows it follows the data and is not a constant;
- a second program over an already written word, which separates an AND merge from an overwrite.

Erases are run with data left in a neighbouring sector, which shows whether the erase stays inside its own sector. Wrong-address unlocks, programs issued while busy, and writes made after leaving shortcut mode are each followed by reads of the target word, so a dropped command can be told apart from an accepted one. Suspends are issued at different points of a run, and a model checks `ready` on every clock, so cycles lost or double counted around a suspend show up as a change in the busy length.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
  localparam int DATA_W = 16;
  localparam int CMD_AW = 12;

  localparam logic [CMD_AW-1:0] ADR_KEY1 = 12'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 12'h2AA;

  localparam logic [7:0] KEY1        = 8'hAA;
  localparam logic [7:0] KEY2        = 8'h55;
  localparam logic [7:0] OP_PROG     = 8'hA0;
  localparam logic [7:0] OP_ER_SETUP = 8'h80;
  localparam logic [7:0] OP_ER_GO    = 8'h30;
  localparam logic [7:0] OP_RESUME   = 8'h30;
  localparam logic [7:0] OP_SUSP     = 8'hB0;
  localparam logic [7:0] OP_FAST_IN  = 8'h20;
  localparam logic [7:0] OP_FAST_X1  = 8'h90;
  localparam logic [7:0] OP_FAST_X2  = 8'h00;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_E1, SQ_E2, SQ_E3, SQ_FDATA, SQ_FEXIT
  } seq_e;

  function automatic logic key_first(input logic [CMD_AW-1:0] a, input logic [7:0] d);
    return (a == ADR_KEY1) && (d == KEY1);
  endfunction

  function automatic logic key_second(input logic [CMD_AW-1:0] a, input logic [7:0] d);
    return (a == ADR_KEY2) && (d == KEY2);
  endfunction

  // Poll word: bit 7 inverted target bit, bit 6 alternating, rest zero
  function automatic logic [DATA_W-1:0] status_word(input logic tgt7, input logic tog);
    logic [DATA_W-1:0] w;
    w = '0;
    w[7] = ~tgt7;
    w[6] = tog;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/ncc_decode.sv
module ncc_decode
  import ncc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_byte,
  input  logic              busy,
  input  logic              p_susp,
  input  logic              e_susp,
  output logic              ev_prog,
  output logic              ev_erase,
  output logic              ev_resume,
  output logic              susp_req
);
  seq_e st_q, st_d;
  logic fast_q, fast_d;

  always_comb begin
    st_d      = st_q;
    fast_d    = fast_q;
    ev_prog   = 1'b0;
    ev_erase  = 1'b0;
    ev_resume = 1'b0;
    susp_req  = 1'b0;
    if (we) begin
      if (busy) begin
        susp_req = (cmd_byte == OP_SUSP);
      end else if (p_susp) begin
        ev_resume = (cmd_byte == OP_RESUME);
      end else begin
        case (st_q)
          SQ_IDLE: begin
            if (fast_q) begin
              if (cmd_byte == OP_PROG)          st_d = SQ_FDATA;
              else if (cmd_byte == OP_FAST_X1)  st_d = SQ_FEXIT;
              else if (e_susp && cmd_byte == OP_RESUME) ev_resume = 1'b1;
            end else if (key_first(cmd_addr, cmd_byte)) begin
              st_d = SQ_K1;
            end else if (e_susp && cmd_byte == OP_RESUME) begin
              ev_resume = 1'b1;
            end
          end
          SQ_K1: st_d = key_second(cmd_addr, cmd_byte) ? SQ_K2 : SQ_IDLE;
          SQ_K2: begin
            st_d = SQ_IDLE;
            if (cmd_addr == ADR_KEY1) begin
              if (cmd_byte == OP_PROG)                      st_d = SQ_PDATA;
              else if (cmd_byte == OP_ER_SETUP && !e_susp)  st_d = SQ_E1;
              else if (cmd_byte == OP_FAST_IN)              fast_d = 1'b1;
            end
          end
          SQ_PDATA, SQ_FDATA: begin
            ev_prog = 1'b1;
            st_d    = SQ_IDLE;
          end
          SQ_E1: st_d = key_first(cmd_addr, cmd_byte) ? SQ_E2 : SQ_IDLE;
          SQ_E2: st_d = key_second(cmd_addr, cmd_byte) ? SQ_E3 : SQ_IDLE;
          SQ_E3: begin
            ev_erase = (cmd_byte == OP_ER_GO);
            st_d     = SQ_IDLE;
          end
          SQ_FEXIT: begin
            if (cmd_byte == OP_FAST_X2) fast_d = 1'b0;
            st_d = SQ_IDLE;
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      fast_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/ncc_engine.sv
module ncc_engine
  import ncc_pkg::*;
#(
  parameter int ARR_AW    = 6,
  parameter int WORD_AW   = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_prog,
  input  logic                      ev_erase,
  input  logic                      ev_resume,
  input  logic                      susp_req,
  input  logic [ARR_AW-1:0]         op_addr,
  input  logic [DATA_W-1:0]         op_data,
  output logic                      busy,
  output logic                      p_act,
  output logic                      p_susp,
  output logic                      e_act,
  output logic                      e_susp,
  output logic [ARR_AW-1:0]         p_addr,
  output logic [DATA_W-1:0]         p_data,
  output logic [ARR_AW-WORD_AW-1:0] e_sec,
  output logic                      prog_done,
  output logic                      erase_done
);
  localparam int SEC_AW = ARR_AW - WORD_AW;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic [CNT_W-1:0] p_cnt, e_cnt;
  logic p_run, e_run, take_p, take_e, prog_ok, erase_ok, res_p, res_e;
  logic [SEC_AW-1:0] op_sec;

  assign op_sec     = op_addr[ARR_AW-1:WORD_AW];
  assign p_run      = p_act & ~p_susp;
  assign e_run      = e_act & ~e_susp;
  assign busy       = p_run | e_run;
  assign take_p     = susp_req & p_run & ~e_susp;
  assign take_e     = susp_req & e_run;
  assign prog_done  = p_run & ~take_p & (p_cnt == '0);
  assign erase_done = e_run & ~take_e & (e_cnt == '0);
  assign prog_ok    = ev_prog & ~busy & ~p_act & ~(e_act & e_susp & (op_sec == e_sec));
  assign erase_ok   = ev_erase & ~busy & ~p_act & ~e_act;
  assign res_p      = ev_resume & ~busy & p_susp;
  assign res_e      = ev_resume & ~busy & ~p_susp & e_susp & ~p_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act  <= 1'b0;
      p_susp <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
      p_cnt  <= '0;
    end else if (prog_ok) begin
      p_act  <= 1'b1;
      p_susp <= 1'b0;
      p_addr <= op_addr;
      p_data <= op_data;
      p_cnt  <= CNT_W'(PROG_CYC - 1);
    end else begin
      if (prog_done)              p_act <= 1'b0;
      else if (p_run && !take_p)  p_cnt <= p_cnt - 1'b1;
      if (take_p)                 p_susp <= 1'b1;
      if (res_p)                  p_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_act  <= 1'b0;
      e_susp <= 1'b0;
      e_sec  <= '0;
      e_cnt  <= '0;
    end else if (erase_ok) begin
      e_act  <= 1'b1;
      e_susp <= 1'b0;
      e_sec  <= op_sec;
      e_cnt  <= CNT_W'(ERASE_CYC - 1);
    end else begin
      if (erase_done)             e_act <= 1'b0;
      else if (e_run && !take_e)  e_cnt <= e_cnt - 1'b1;
      if (take_e)                 e_susp <= 1'b1;
      if (res_e)                  e_susp <= 1'b0;
    end
  end
endmodule

// File: rtl/ncc_array.sv
module ncc_array
  import ncc_pkg::*;
#(
  parameter int ARR_AW  = 6,
  parameter int WORD_AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_done,
  input  logic [ARR_AW-1:0]         p_addr,
  input  logic [DATA_W-1:0]         p_data,
  input  logic                      erase_done,
  input  logic [ARR_AW-WORD_AW-1:0] e_sec,
  input  logic [ARR_AW-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_word
);
  localparam int WORDS      = 1 << ARR_AW;
  localparam int SECT_WORDS = 1 << WORD_AW;

  logic [DATA_W-1:0] mem [WORDS];

  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (prog_done) mem[p_addr] <= merge_word(mem[p_addr], p_data);
      if (erase_done) begin
        for (int i = 0; i < SECT_WORDS; i++) mem[{e_sec, WORD_AW'(i)}] <= '1;
      end
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import ncc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SECT_NUM   = 4,
  parameter int SECT_WORDS = 16,
  parameter int PROG_CYC   = 6,
  parameter int ERASE_CYC  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ready
);
  localparam int WORD_AW = $clog2(SECT_WORDS);
  localparam int SEC_AW  = $clog2(SECT_NUM);
  localparam int ARR_AW  = WORD_AW + SEC_AW;

  logic ev_prog, ev_erase, ev_resume, susp_req;
  logic busy, p_act, p_susp, e_act, e_susp, prog_done, erase_done;
  logic [ARR_AW-1:0] p_addr, arr_addr;
  logic [DATA_W-1:0] p_data, arr_q;
  logic [SEC_AW-1:0] e_sec, rd_sec;
  logic status_rd, tog_q, tgt7;

  assign arr_addr = host_addr[ARR_AW-1:0];
  assign rd_sec   = arr_addr[ARR_AW-1:WORD_AW];

  ncc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .we(host_we),
    .cmd_addr(host_addr[CMD_AW-1:0]), .cmd_byte(host_wdata[7:0]),
    .busy(busy), .p_susp(p_susp), .e_susp(e_susp),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_resume(ev_resume), .susp_req(susp_req)
  );

  ncc_engine #(.ARR_AW(ARR_AW), .WORD_AW(WORD_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_resume(ev_resume), .susp_req(susp_req),
    .op_addr(arr_addr), .op_data(host_wdata),
    .busy(busy), .p_act(p_act), .p_susp(p_susp), .e_act(e_act), .e_susp(e_susp),
    .p_addr(p_addr), .p_data(p_data), .e_sec(e_sec),
    .prog_done(prog_done), .erase_done(erase_done)
  );

  ncc_array #(.ARR_AW(ARR_AW), .WORD_AW(WORD_AW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_done(prog_done), .p_addr(p_addr), .p_data(p_data),
    .erase_done(erase_done), .e_sec(e_sec),
    .rd_addr(arr_addr), .rd_word(arr_q)
  );

  assign ready     = ~busy;
  assign tgt7      = p_act ? p_data[7] : 1'b1;
  assign status_rd = host_rd & (busy
                   | (p_act & p_susp & (rd_sec == p_addr[ARR_AW-1:WORD_AW]))
                   | (e_act & e_susp & (rd_sec == e_sec)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      tog_q      <= 1'b0;
    end else if (host_rd) begin
      if (status_rd) begin
        host_rdata <= status_word(tgt7, tog_q);
        tog_q      <= ~tog_q;
      end else begin
        host_rdata <= arr_q;
      end
    end
  end
endmodule

// File: rtl/ncc_checker.sv
module ncc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic [15:0] host_rdata,
  input logic        ev_prog,
  input logic        ev_erase,
  input logic        ev_resume,
  input logic        susp_req,
  input logic        prog_done,
  input logic        erase_done,
  input logic        status_rd,
  input logic        busy,
  input logic        e_susp
);
  // R11
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ev_prog || ev_erase));

  // R6
  ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(prog_done || erase_done || susp_req));

  // R6
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(ev_prog || ev_erase || ev_resume));

  // R7
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (host_rdata[15:8] == 8'h00) && (host_rdata[5:0] == 6'h00));

  // R8
  suspend_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && busy && !e_susp) |=> ready);
endmodule

bind nor_cmd_ctrl ncc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .host_rdata(host_rdata),
  .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_resume(ev_resume), .susp_req(susp_req),
  .prog_done(prog_done), .erase_done(erase_done), .status_rd(status_rd),
  .busy(busy), .e_susp(e_susp)
);

// File: tb/tb_nor_cmd_ctrl.sv
module tb_nor_cmd_ctrl;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 12;
  localparam int EV_P = 1, EV_E = 2, EV_S = 3, EV_R = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ready;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(12), .SECT_NUM(4), .SECT_WORDS(16),
                 .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ready(ready));

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_mem [64];
  int  m_evk = 0;
  bit  m_pa, m_ps, m_ea, m_es, m_tog;
  int  m_pleft, m_eleft, m_esec;
  logic [5:0]  m_paddr;
  logic [15:0] m_pdata, m_exp;

  function automatic bit m_busy();
    return (m_pa && !m_ps) || (m_ea && !m_es);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
      m_pa = 0; m_ps = 0; m_ea = 0; m_es = 0; m_tog = 0; m_exp = '0;
    end else begin
      bit bz, pr, er, tp, te, st;
      int sec;
      bz = m_busy();
      pr = m_pa && !m_ps;
      er = m_ea && !m_es;
      if (host_rd) begin
        sec = int'(host_addr[5:4]);
        st = bz || (m_pa && m_ps && sec == int'(m_paddr[5:4])) || (m_ea && m_es && sec == m_esec);
        if (st) begin
          m_exp = 16'h0000;
          m_exp[7] = m_pa ? ~m_pdata[7] : 1'b0;
          m_exp[6] = m_tog;
          m_tog = ~m_tog;
        end else m_exp = m_mem[host_addr[5:0]];
      end
      tp = 0; te = 0;
      if (m_evk == EV_S) begin
        if (pr && !m_es) begin m_ps = 1; tp = 1; end
        else if (er) begin m_es = 1; te = 1; end
      end
      if (pr && !tp) begin
        if (m_pleft == 0) begin m_mem[m_paddr] = m_mem[m_paddr] & m_pdata; m_pa = 0; end
        else m_pleft--;
      end
      if (er && !te) begin
        if (m_eleft == 0) begin
          for (int w = 0; w < 16; w++) m_mem[m_esec*16 + w] = 16'hFFFF;
          m_ea = 0;
        end else m_eleft--;
      end
      if (m_evk == EV_R && !bz) begin
        if (m_ps) m_ps = 0;
        else if (m_es && !m_pa) m_es = 0;
      end
      if (m_evk == EV_P && !bz && !m_pa && !(m_ea && m_es && int'(host_addr[5:4]) == m_esec)) begin
        m_pa = 1; m_ps = 0; m_paddr = host_addr[5:0]; m_pdata = host_wdata; m_pleft = PROG_CYC - 1;
      end
      if (m_evk == EV_E && !bz && !m_pa && !m_ea) begin
        m_ea = 1; m_es = 0; m_esec = int'(host_addr[5:4]); m_eleft = ERASE_CYC - 1;
      end
    end
  end

  // R6: ready compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      tests++;
      if (ready !== !m_busy()) begin
        fails++;
        $display("FAIL R6 ready at %0t: actual %b expected %b", $time, ready, !m_busy());
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [11:0] wa(input int s, input int w);
    return 12'(s * 16 + w);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d, input int ev = 0);
    host_we = 1; host_addr = a; host_wdata = d; m_evk = ev;
    @(negedge clk);
    host_we = 0; m_evk = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0;
    chk(host_rdata === m_exp, tag, host_rdata, m_exp);
  endtask

  task automatic prog4(input logic [11:0] a, input logic [15:0] d);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d, EV_P);
  endtask

  task automatic erase6(input int s);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(wa(s, 0), 16'h0030, EV_E);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    chk(ready === 1'b1, "R10 reset ready", 16'(ready), 16'h1);
    rd(wa(0, 1), "R10 erased after reset");
    chk(host_rdata === 16'hFFFF, "R10 literal", host_rdata, 16'hFFFF);

    // R1 four-write program, R7 polling
    prog4(wa(0, 1), 16'h12F4);
    rd(wa(3, 0), "R7 first poll");
    rd(wa(3, 0), "R7 second poll");
    chk(host_rdata === 16'h0040, "R7 toggle and bit7", host_rdata, 16'h0040);
    idle(PROG_CYC + 1);
    rd(wa(0, 1), "R1 programmed word");
    chk(host_rdata === 16'h12F4, "R1 literal", host_rdata, 16'h12F4);

    // R2 bit clearing only
    prog4(wa(0, 1), 16'hFF0F);
    idle(PROG_CYC + 1);
    rd(wa(0, 1), "R2 and-merge");
    chk(host_rdata === 16'h1204, "R2 literal", host_rdata, 16'h1204);

    // R11 writes during busy ignored
    prog4(wa(0, 2), 16'h0070);
    rd(wa(0, 2), "R7 poll bit7 clear data");
    prog4(wa(0, 3), 16'h0000);
    idle(PROG_CYC + 1);
    rd(wa(0, 3), "R11 busy write ignored");
    rd(wa(0, 2), "R1 second program");

    // R5 broken unlock
    wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h00A0); wr(wa(0, 4), 16'h0000);
    idle(PROG_CYC + 1);
    rd(wa(0, 4), "R5 mismatch drops sequence");
    chk(host_rdata === 16'hFFFF, "R5 literal", host_rdata, 16'hFFFF);

    // R4 sector erase leaves neighbours
    prog4(wa(1, 0), 16'h5A5A);
    idle(PROG_CYC + 1);
    erase6(0);
    rd(wa(2, 0), "R7 erase poll");
    idle(ERASE_CYC + 1);
    rd(wa(0, 1), "R4 erased word");
    chk(host_rdata === 16'hFFFF, "R4 literal", host_rdata, 16'hFFFF);
    rd(wa(1, 0), "R4 neighbour kept");
    chk(host_rdata === 16'h5A5A, "R4 neighbour literal", host_rdata, 16'h5A5A);

    // R3 shortcut mode
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0020);
    wr(12'h000, 16'h00A0); wr(wa(2, 3), 16'h0F0F, EV_P);
    idle(PROG_CYC + 1);
    rd(wa(2, 3), "R3 two-write program");
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
    wr(12'h000, 16'h00A0); wr(wa(2, 4), 16'h0000);
    idle(PROG_CYC + 1);
    rd(wa(2, 4), "R3 exit restores normal mode");
    chk(host_rdata === 16'hFFFF, "R3 literal", host_rdata, 16'hFFFF);

    // R8 erase suspend
    erase6(1);
    idle(3);
    wr(12'h000, 16'h00B0, EV_S);
    rd(wa(1, 0), "R8 suspended sector gives status");
    rd(wa(2, 3), "R8 other sector readable");
    prog4(wa(2, 5), 16'h00AA);
    idle(PROG_CYC + 1);
    rd(wa(2, 5), "R8 program in other sector");
    prog4(wa(1, 1), 16'h0000);
    idle(2);
    erase6(3);
    idle(2);
    wr(wa(0, 0), 16'h0030, EV_R);
    idle(ERASE_CYC + 1);
    rd(wa(1, 0), "R8 erase completes after resume");
    rd(wa(1, 1), "R8 program to suspended sector ignored");
    chk(host_rdata === 16'hFFFF, "R8 literal", host_rdata, 16'hFFFF);

    // R9 program suspend
    prog4(wa(3, 2), 16'h0000);
    idle(2);
    wr(12'h000, 16'h00B0, EV_S);
    rd(wa(0, 0), "R9 other sector readable");
    rd(wa(3, 2), "R9 own sector gives status");
    prog4(wa(0, 6), 16'h1234);
    wr(wa(0, 0), 16'h0030, EV_R);
    idle(PROG_CYC + 1);
    rd(wa(3, 2), "R9 program completes after resume");
    chk(host_rdata === 16'h0000, "R9 literal", host_rdata, 16'h0000);
    rd(wa(0, 6), "R9 write during suspend ignored");

    // R10 reset aborts
    erase6(2);
    idle(3);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    chk(ready === 1'b1, "R10 ready after abort", 16'(ready), 16'h1);
    rd(wa(2, 3), "R10 read mode after abort");
    prog4(wa(2, 3), 16'h00F0);
    idle(PROG_CYC + 1);
    rd(wa(2, 3), "R10 new command works");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule